// File: doc/BRIEF.md
# Local-History Criticality Predictor

This block guesses whether the next dynamic instance of a static instruction will lie on the program's critical path. It keeps, for each instruction slot, a short record of whether recent instances turned out critical. That record, together with a few low instruction-address bits, selects a small saturating counter. The counter's upper half means "predict critical". This two-level arrangement lets the predictor follow periodic behaviour. One example is a load that misses, and so becomes critical, only on every fourth execution. A single counter per instruction never reaches its threshold on such a load.

The front end presents an instruction address on the lookup port and receives a prediction in the same cycle. When some downstream mechanism has decided whether an executed instance was critical, it presents the address and that outcome on the training port for one cycle. Both tables are updated on the following clock edge.

Top module: `crit_lhist_pred`

## Requirements
- R1: After reset every history register is zero and every pattern counter holds 1, so a lookup of any address predicts non-critical.
- R2: The lookup output is combinational. It is 1 exactly when the counter at index {history(lk_pc), lk_pc[3:2]} is 2 or more, where history(pc) is the register selected by pc[5:2].
- R3: A training event shifts the 4-bit history selected by tr_pc[5:2] one place toward the MSB, and the outcome enters at bit 0.
- R4: A training event increments the counter selected by the history value before the shift (and tr_pc[3:2]) when the outcome is critical, and decrements it otherwise.
- R5: Counters saturate at 3 when incremented and at 0 when decremented, without wrapping.
- R6: A lookup in the same cycle as a training event to the same entry returns the prediction from before the update.
- R7: While tr_valid is low, no history register or counter changes, whatever tr_pc and tr_crit carry.
- R8: Two addresses with different pc[3:2] use distinct counters even when their histories are equal.
- R9: An instruction trained with the repeating pattern non-critical, non-critical, non-critical, critical is predicted correctly on every instance from the third period onward.
- R10: An instruction trained with alternating critical and non-critical outcomes, starting with critical, is predicted correctly from the sixth instance onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_pc | input | 32 | Address of the instruction being predicted |
| lk_crit | output | 1 | 1 = predicted critical |
| tr_valid | input | 1 | Training event present this cycle |
| tr_pc | input | 32 | Address of the resolved instruction |
| tr_crit | input | 1 | Resolved outcome, 1 = critical |

## Verification
A history register holding a wrong bit shows at the ports only through the counter it selects. That is visible on the next lookup of the same address, provided the two candidate counters differ, so the tests first train counters apart and then probe them. A corrupted counter shows on the very next lookup whose history selects it. A wrap instead of saturation flips a saturated "critical" into "non-critical" one cycle after the extra increment. A shift in the wrong direction or a lost address bit in the index breaks the learned periodic and alternating patterns within one period.

// File: rtl/crit_lhist_pred.sv
module crit_lhist_pred #(
  parameter int PC_W        = 32,
  parameter int PC_LO       = 2,
  parameter int HT_BITS     = 4,
  parameter int HIST_W      = 4,
  parameter int PAT_PC_BITS = 2,
  parameter int CTR_W       = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] lk_pc,
  output logic            lk_crit,
  input  logic            tr_valid,
  input  logic [PC_W-1:0] tr_pc,
  input  logic            tr_crit
);

  localparam int HT_N     = 1 << HT_BITS;
  localparam int PT_BITS  = HIST_W + PAT_PC_BITS;
  localparam int PT_N     = 1 << PT_BITS;
  localparam int CTR_THR  = 1 << (CTR_W - 1);
  localparam int CTR_INIT = CTR_THR - 1;
  localparam int CTR_MAX  = (1 << CTR_W) - 1;

  logic [HT_N-1:0][HIST_W-1:0] hist_q;
  logic [PT_N-1:0][CTR_W-1:0]  ctr_q;

  logic [HT_BITS-1:0] lk_hidx, tr_hidx;
  logic [PT_BITS-1:0] lk_pidx, tr_pidx;
  logic [HIST_W-1:0]  tr_hist;
  logic [CTR_W-1:0]   tr_ctr, tr_ctr_nxt;
  logic               unused_pc;

  assign lk_hidx = lk_pc[PC_LO +: HT_BITS];
  assign tr_hidx = tr_pc[PC_LO +: HT_BITS];
  assign tr_hist = hist_q[tr_hidx];
  assign lk_pidx = {hist_q[lk_hidx], lk_pc[PC_LO +: PAT_PC_BITS]};
  assign tr_pidx = {tr_hist, tr_pc[PC_LO +: PAT_PC_BITS]};
  assign tr_ctr  = ctr_q[tr_pidx];
  assign lk_crit = ctr_q[lk_pidx] >= CTR_W'(CTR_THR);
  assign unused_pc = &{1'b0, lk_pc, tr_pc};

  always_comb begin
    tr_ctr_nxt = tr_ctr;
    if (tr_crit) begin
      if (tr_ctr != CTR_W'(CTR_MAX)) tr_ctr_nxt = tr_ctr + 1'b1;
    end else begin
      if (tr_ctr != '0) tr_ctr_nxt = tr_ctr - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist_q <= '0;
      ctr_q  <= {PT_N{CTR_W'(CTR_INIT)}};
    end else if (tr_valid) begin
      hist_q[tr_hidx] <= {tr_hist[HIST_W-2:0], tr_crit};
      ctr_q[tr_pidx]  <= tr_ctr_nxt;
    end
  end

  a_r3_hist_shift: assert property (@(posedge clk) disable iff (!rst_n)
    tr_valid |=> hist_q[$past(tr_hidx)] == {$past(tr_hist[HIST_W-2:0]), $past(tr_crit)});

  a_r4_inc: assert property (@(posedge clk) disable iff (!rst_n)
    (tr_valid && tr_crit && tr_ctr != CTR_W'(CTR_MAX))
      |=> ctr_q[$past(tr_pidx)] == $past(tr_ctr) + CTR_W'(1));

  a_r4_dec: assert property (@(posedge clk) disable iff (!rst_n)
    (tr_valid && !tr_crit && tr_ctr != '0)
      |=> ctr_q[$past(tr_pidx)] == $past(tr_ctr) - CTR_W'(1));

  a_r5_sat_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (tr_valid && tr_crit && tr_ctr == CTR_W'(CTR_MAX))
      |=> ctr_q[$past(tr_pidx)] == CTR_W'(CTR_MAX));

  a_r5_sat_lo: assert property (@(posedge clk) disable iff (!rst_n)
    (tr_valid && !tr_crit && tr_ctr == '0) |=> ctr_q[$past(tr_pidx)] == '0);

  a_r7_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !tr_valid |=> ($stable(hist_q) && $stable(ctr_q)));

endmodule

// File: tb/test_crit_lhist_pred.sv
module test_crit_lhist_pred;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] lk_pc = '0;
  logic        lk_crit;
  logic        tr_valid = 1'b0;
  logic [31:0] tr_pc = '0;
  logic        tr_crit = 1'b0;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  crit_lhist_pred i_crit_lhist_pred (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_crit(lk_crit),
    .tr_valid(tr_valid), .tr_pc(tr_pc), .tr_crit(tr_crit)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: lk_crit=%0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; tr_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic train(input logic [31:0] pc, input logic c);
    @(negedge clk);
    tr_valid = 1'b1; tr_pc = pc; tr_crit = c;
  endtask

  task automatic train_chk(input logic [31:0] pc, input logic c,
                           input logic exp, input string tag);
    @(negedge clk);
    tr_valid = 1'b1; tr_pc = pc; tr_crit = c; lk_pc = pc;
    #1 check(tag, lk_crit, exp);
  endtask

  task automatic look(input logic [31:0] pc, input logic exp, input string tag);
    @(negedge clk);
    tr_valid = 1'b0; lk_pc = pc;
    #1 check(tag, lk_crit, exp);
  endtask

  task automatic t_reset();
    do_reset();
    look(32'h100, 1'b0, "R1 pc 0x100");
    look(32'h104, 1'b0, "R1 pc 0x104");
    look(32'h13C, 1'b0, "R1 pc 0x13C");
    look(32'hFFFF_FFFC, 1'b0, "R1 pc top");
  endtask

  task automatic t_idle();
    do_reset();
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      tr_valid = 1'b0; tr_pc = 32'h108; tr_crit = 1'b1;
    end
    look(32'h108, 1'b0, "R7 idle training ignored");
  endtask

  task automatic t_sat_hi();
    do_reset();
    for (int i = 0; i < 8; i++) train(32'h108, 1'b1);
    look(32'h108, 1'b1, "R5 saturate high");
    train_chk(32'h108, 1'b0, 1'b1, "R6 pre-update prediction");
    look(32'h108, 1'b0, "R3 outcome enters at bit 0");
  endtask

  task automatic t_sat_lo();
    do_reset();
    for (int i = 0; i < 3; i++) train(32'h10C, 1'b0);
    train(32'h10C, 1'b1);
    for (int i = 0; i < 4; i++) train(32'h10C, 1'b0);
    look(32'h10C, 1'b0, "R5 saturate low");
    train(32'h10C, 1'b1);
    look(32'h10C, 1'b0, "R4 counter at history 0001");
  endtask

  task automatic t_period();
    do_reset();
    for (int p = 0; p < 2; p++)
      for (int k = 0; k < 4; k++) train(32'h100, k == 3);
    for (int p = 0; p < 2; p++)
      for (int k = 0; k < 4; k++)
        train_chk(32'h100, k == 3, k == 3, "R9 R4 R6 period-4 pattern");
  endtask

  task automatic t_alt();
    do_reset();
    for (int n = 1; n <= 10; n++) begin
      if (n < 6) train(32'h104, n[0]);
      else train_chk(32'h104, n[0], n[0], "R10 alternating pattern");
    end
  endtask

  task automatic t_alias();
    do_reset();
    for (int i = 0; i < 8; i++) train(32'h110, 1'b1);
    for (int i = 0; i < 4; i++) train(32'h114, 1'b1);
    look(32'h114, 1'b0, "R8 distinct counter by pc bits");
    look(32'h110, 1'b1, "R2 lookup reflects counter");
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_idle();
    t_sat_hi();
    t_sat_lo();
    t_period();
    t_alt();
    t_alias();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule